// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block holds the micro-program counter of a microcoded control unit and works out its next value once per microcycle. The current microinstruction supplies a successor address and three branch bits. One bit ORs the fetched opcode byte into the low part of that address. The other two bits force the top address bit high when the ALU zero or negative flag, latched at the end of the previous microcycle, is set.

Instruction decode needs no lookup table. With a successor address whose low eight bits are zero and the dispatch bit set, the opcode itself becomes the entry point. Every instruction entry therefore lies in the lower half of the control store. Conditional microbranches land in the upper half, at the same offset as their fall-through address.

Top module: `mpc_sequencer`

## Requirements
- R1: While `rst` is high at a rising edge, `mpc` becomes 0x000 and both latched flags become 0. A conditional branch issued in the first cycle after reset therefore falls through.
- R2: With `jmp`, `jmpz` and `jmpn` all low, the next `mpc` equals `next_addr`.
- R3: With `jmp` high, bits 7..0 of the next `mpc` equal `mbr` bitwise-OR bits 7..0 of `next_addr`.
- R4: With `jmp` high and `next_addr` equal to 0x000, the next `mpc` equals `mbr` zero-extended. This is the opcode dispatch.
- R5: With `jmp` high and no condition taken, bit 8 of the next `mpc` is bit 8 of `next_addr`.
- R6: With `jmpz` high and the latched zero flag at 1, bit 8 of the next `mpc` is 1.
- R7: With `jmpn` high and the latched negative flag at 1, bit 8 of the next `mpc` is 1.
- R8: The flags used by a microinstruction are the `alu_z`/`alu_n` values present one clock earlier. Flag inputs in the same cycle do not affect that cycle's branch.
- R9: A condition bit whose own flag is 0 does not set bit 8, even when the other flag is 1. Either condition being met is enough.
- R10: The dispatch OR and a taken condition combine: the low 8 bits follow R3 while bit 8 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Microcycle clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| next_addr | input | 9 | Successor address field of current microinstruction |
| jmp | input | 1 | OR the opcode byte into the low address bits |
| jmpz | input | 1 | Branch to upper half if latched zero flag set |
| jmpn | input | 1 | Branch to upper half if latched negative flag set |
| alu_z | input | 1 | ALU zero result of this microcycle |
| alu_n | input | 1 | ALU negative result of this microcycle |
| mbr | input | 8 | Fetched opcode/operand byte |
| mpc | output | 9 | Registered micro-program counter |

## Verification
The bench uses the default nine-bit control-store address and eight-bit opcode. With these widths, every opcode value and both halves of the control store can be reached in a short run. Directed steps cover the dispatch and the upper-half branches. They also place a flag change in the same cycle as a conditional branch to show the one-cycle flag delay. Several hundred random microcycles then mix all branch-bit combinations with reset pulses against a behavioural model.

// File: rtl/mpc_seq_pkg.sv
package mpc_seq_pkg;

    typedef struct packed {
        logic zero;
        logic neg;
    } alu_flags_t;

    typedef struct packed {
        logic dispatch;
        logic on_zero;
        logic on_neg;
    } branch_ctl_t;

endpackage

// File: rtl/mpc_cond_flags.sv
module mpc_cond_flags
    import mpc_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  alu_flags_t alu_now,
    output alu_flags_t flags_q
);

    alu_flags_t flags_d;

    always_comb begin
        flags_d = alu_now;
        if (rst) begin
            flags_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        flags_q <= flags_d;
    end

    a_r8_flags_follow: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (flags_q == $past(alu_now)));
    a_r1_flags_reset: assert property (@(posedge clk)
        rst |=> (flags_q == '0));

endmodule

// File: rtl/mpc_addr_mux.sv
module mpc_addr_mux
    import mpc_seq_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int OPC_W  = 8
) (
    input  logic [ADDR_W-1:0] next_addr,
    input  logic [OPC_W-1:0]  mbr,
    input  branch_ctl_t       ctl,
    input  alu_flags_t        flags,
    output logic [ADDR_W-1:0] addr_d
);

    localparam int TOP = ADDR_W - 1;

    logic take_hi;

    always_comb begin
        take_hi = (ctl.on_zero & flags.zero) | (ctl.on_neg & flags.neg);
        addr_d  = next_addr;
        if (ctl.dispatch) begin
            addr_d[OPC_W-1:0] = next_addr[OPC_W-1:0] | mbr;
        end
        if (take_hi) begin
            addr_d[TOP] = 1'b1;
        end
    end

endmodule

// File: rtl/mpc_sequencer.sv
module mpc_sequencer
    import mpc_seq_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int OPC_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] next_addr,
    input  logic              jmp,
    input  logic              jmpz,
    input  logic              jmpn,
    input  logic              alu_z,
    input  logic              alu_n,
    input  logic [OPC_W-1:0]  mbr,
    output logic [ADDR_W-1:0] mpc
);

    localparam int TOP = ADDR_W - 1;

    branch_ctl_t       ctl;
    alu_flags_t        alu_now;
    alu_flags_t        flags_q;
    logic [ADDR_W-1:0] sel_addr;
    logic [ADDR_W-1:0] mpc_d;
    logic [ADDR_W-1:0] mpc_q;

    assign ctl     = '{dispatch: jmp, on_zero: jmpz, on_neg: jmpn};
    assign alu_now = '{zero: alu_z, neg: alu_n};

    mpc_cond_flags i_flags (
        .clk     (clk),
        .rst     (rst),
        .alu_now (alu_now),
        .flags_q (flags_q)
    );

    mpc_addr_mux #(
        .ADDR_W (ADDR_W),
        .OPC_W  (OPC_W)
    ) i_mux (
        .next_addr (next_addr),
        .mbr       (mbr),
        .ctl       (ctl),
        .flags     (flags_q),
        .addr_d    (sel_addr)
    );

    always_comb begin
        mpc_d = sel_addr;
        if (rst) begin
            mpc_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        mpc_q <= mpc_d;
    end

    assign mpc = mpc_q;

    a_r1_reset_zero: assert property (@(posedge clk)
        rst |=> (mpc_q == '0));
    a_r2_straight: assert property (@(posedge clk) disable iff (rst)
        (!jmp && !jmpz && !jmpn) |=> (mpc_q == $past(next_addr)));
    a_r3_or_low: assert property (@(posedge clk) disable iff (rst)
        jmp |=> (mpc_q[OPC_W-1:0] == ($past(mbr) | $past(next_addr[OPC_W-1:0]))));
    a_r5_top_pass: assert property (@(posedge clk) disable iff (rst)
        (!jmpz && !jmpn) |=> (mpc_q[TOP] == $past(next_addr[TOP])));
    a_r6_zero_hi: assert property (@(posedge clk) disable iff (rst)
        (jmpz && flags_q.zero) |=> mpc_q[TOP]);
    a_r7_neg_hi: assert property (@(posedge clk) disable iff (rst)
        (jmpn && flags_q.neg) |=> mpc_q[TOP]);

endmodule

// File: tb/test_mpc_sequencer.sv
module test_mpc_sequencer;

    logic       clk = 1'b0;
    logic       rst;
    logic [8:0] next_addr;
    logic       jmp, jmpz, jmpn, alu_z, alu_n;
    logic [7:0] mbr;
    logic [8:0] mpc;

    int checks = 0;
    int fails  = 0;
    int ref_z  = 0;
    int ref_n  = 0;

    always #5 clk = ~clk;

    mpc_sequencer i_mpc_sequencer (
        .clk(clk), .rst(rst), .next_addr(next_addr), .jmp(jmp), .jmpz(jmpz),
        .jmpn(jmpn), .alu_z(alu_z), .alu_n(alu_n), .mbr(mbr), .mpc(mpc)
    );

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: mpc actual 0x%03h expected 0x%03h", tag, got, exp);
        end
    endtask

    // one microcycle: drive at negedge, predict, sample after the edge
    task automatic step(input string tag, input bit r, input int na, input bit j,
                        input bit jz, input bit jn, input bit az, input bit an,
                        input int mb);
        int exp;
        @(negedge clk);
        rst = r; next_addr = 9'(na); jmp = j; jmpz = jz; jmpn = jn;
        alu_z = az; alu_n = an; mbr = 8'(mb);
        exp = na & 'h1FF;
        if (j) exp = (exp & 'h100) | ((na | mb) & 'hFF);
        if ((jz && ref_z != 0) || (jn && ref_n != 0)) exp = exp | 'h100;
        if (r) begin
            exp = 0; ref_z = 0; ref_n = 0;
        end else begin
            ref_z = az; ref_n = an;
        end
        @(posedge clk);
        #1;
        check(tag, int'(mpc), exp);
    endtask

    function automatic string pick_tag(bit r, bit j, bit jz, bit jn);
        if (r) return "R1";
        if (j && (jz || jn)) return "R10";
        if (j) return "R3";
        if (jz && jn) return "R9";
        if (jz) return "R6";
        if (jn) return "R7";
        return "R2";
    endfunction

    initial begin
        #(200000 * 10);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; next_addr = '0; jmp = 0; jmpz = 0; jmpn = 0;
        alu_z = 0; alu_n = 0; mbr = '0;
        step("R1", 1, 'h1FF, 1, 1, 1, 1, 1, 'hFF);
        step("R1", 1, 'h0AA, 0, 0, 0, 1, 1, 'h12);
        // R1: flags cleared, conditional branch falls through
        step("R1", 0, 'h005, 0, 1, 1, 0, 0, 'h00);
        step("R2", 0, 'h1A3, 0, 0, 0, 0, 0, 'h55);
        step("R4", 0, 'h000, 1, 0, 0, 0, 0, 'h10);
        step("R4", 0, 'h000, 1, 0, 0, 0, 0, 'hFF);
        step("R3", 0, 'h0F0, 1, 0, 0, 0, 0, 'h0F);
        step("R3", 0, 'h002, 1, 0, 0, 0, 0, 'h60);
        step("R5", 0, 'h100, 1, 0, 0, 0, 0, 'h57);
        // R6: raise zero, branch on it next cycle
        step("R6", 0, 'h00C, 0, 0, 0, 1, 0, 'h00);
        step("R6", 0, 'h00C, 0, 1, 0, 0, 0, 'h00);
        // R8: flag arriving in the same cycle is not used
        step("R8", 0, 'h00D, 0, 1, 0, 1, 0, 'h00);
        step("R8", 0, 'h00D, 0, 0, 1, 0, 1, 'h00);
        // R7: negative latched from previous cycle
        step("R7", 0, 'h033, 0, 0, 1, 0, 1, 'h00);
        // R9: zero test with only negative set does not branch
        step("R9", 0, 'h044, 0, 1, 0, 0, 1, 'h00);
        step("R9", 0, 'h045, 0, 1, 1, 0, 0, 'h00);
        // R10: dispatch plus taken condition
        step("R10", 0, 'h000, 0, 0, 0, 0, 1, 'h00);
        step("R10", 0, 'h000, 1, 0, 1, 0, 0, 'h33);
        step("R1", 1, 'h123, 1, 0, 0, 0, 0, 'h01);
        for (int i = 0; i < 400; i++) begin
            bit r, j, jz, jn;
            r  = ($urandom_range(0, 31) == 0);
            j  = 1'($urandom);
            jz = 1'($urandom);
            jn = 1'($urandom);
            step(pick_tag(r, j, jz, jn), r, int'($urandom_range(0, 511)), j, jz, jn,
                 1'($urandom), 1'($urandom), int'($urandom_range(0, 255)));
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule